// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block connects a single-request internal bus port to an asynchronous external static memory bus that has four chip-select banks. Each bank has its own static configuration: an external data width and six wait-state counts. The block accepts one read or write of byte, halfword or word size. It holds the requester off while it runs the external cycles, and it splits write data or assembles read data whenever the selected bank is narrower than the transfer.

The requester raises `reqValid` with the command fields and keeps them steady until `rdy` pulses. `rdy` is high for exactly one clock, during the final external cycle. On a read, `rdata` is valid in that same cycle. Internal data is right-justified: byte k of a transfer always sits in bits 8k+7:8k. Sub-accesses use incrementing byte addresses. Reads that need several sub-accesses run as one page burst, with chip select held low throughout. Each write sub-access is a separate strobe, followed by idle cycles. No write is posted, so a write is on the bus before the requester is released.

Top module: `smemSeq`

## Requirements
- R1: The bank is the top two bits of `reqAddr` (bits 11:10 by default). Only that bank's active-low chip select is asserted during its external cycles, and all chip selects are high while the block is idle.
- R2: A bank width code of 0 selects an 8-bit bank, 1 selects 16 bits, and 2 or 3 select 32 bits. A transfer of S bytes to a bank of W bytes with S > W takes S/W sub-accesses. Otherwise it takes one.
- R3: Sub-access k addresses byte `reqAddr + k*min(S,W)`. Byte j of the transfer maps to internal data bits 8j+7:8j and to external byte address `reqAddr + j`. Only the addressed byte lanes are strobed low. Read data above S bytes is zero, and write data above S bytes has no effect.
- R4: The first read sub-access keeps chip select low for rdWait+1 cycles. Output enable goes low from cycle min(oeDelay, rdWait) until the end of that sub-access.
- R5: Each later sub-access of a read lasts pageWait+1 cycles. Chip select and output enable stay low, with no gap.
- R6: Each write sub-access keeps chip select low for wrWait+1 cycles. Write enable goes low from cycle min(weDelay, wrWait) until the end of that sub-access. Output enable and write enable are never low together.
- R7: After a read completes, turnWait idle cycles pass with all chip selects high. After every write sub-access, max(turnWait,1) idle cycles pass. A waiting request is accepted one cycle after the idle cycles end.
- R8: `rdy` is high for exactly one cycle: the final external cycle of the transfer. On a read, `rdata` holds the assembled word during that cycle.
- R9: While reset is asserted and right after it, all chip selects, output enable and write enable are high and `rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present, held until rdy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | ADDR_W | Byte address; top bits pick the bank |
| reqWdata | input | 32 | Right-justified write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Right-justified read data, valid with rdy |
| cfgWidth | input | 2*NBANK | Width code per bank |
| cfgRdWait | input | NBANK*WAIT_W | Read access wait per bank |
| cfgWrWait | input | NBANK*WAIT_W | Write access wait per bank |
| cfgOeDelay | input | NBANK*WAIT_W | Chip select to output enable delay per bank |
| cfgWeDelay | input | NBANK*WAIT_W | Chip select to write enable delay per bank |
| cfgPageWait | input | NBANK*WAIT_W | Page read wait per bank |
| cfgTurnWait | input | NBANK*WAIT_W | Turnaround idle count per bank |
| memCsN | output | NBANK | Chip selects, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBlsN | output | 4 | Byte lane strobes, active low |
| memAddr | output | ADDR_W | External byte address |
| memDout | output | 32 | External write data |
| memDin | input | 32 | External read data |

## Verification
The bench sweeps every bank and every transfer size at several aligned offsets, using a different width and wait-state mix on each bank. It writes first, then reads back through a byte-addressed memory model. A datapath with the lane order reversed, or a wrong byte lane, would corrupt the neighbouring bytes or return scrambled words. A sequencer that miscounts sub-accesses, page cycles or the strobe start would show up in the per-transfer counts of total cycles, write-enable-low cycles and output-enable-low cycles. Two turnaround cases are covered: a zero turnaround on a write, which must still leave one idle cycle, and a delay set beyond the access length, which must be clamped rather than drop the strobe. A turnaround that is skipped or doubled changes the number of idle cycles measured before the next request starts.

// File: rtl/smemPkg.sv
package smemPkg;
  localparam int BUS_W = 32;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_TURN = 2'd2
  } seqStateT;

  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // fold current read piece into the result
    logic step;     // advance to the next sub-access
  } dpStrobeT;
endpackage

// File: rtl/smemDatapath.sv
module smemDatapath
  import smemPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NBANK  = 4,
  parameter int WAIT_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobeT                strobe,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [BUS_W-1:0]        reqWdata,
  input  logic [2*NBANK-1:0]      cfgWidth,
  input  logic [NBANK*WAIT_W-1:0] cfgRdWait,
  input  logic [NBANK*WAIT_W-1:0] cfgWrWait,
  input  logic [NBANK*WAIT_W-1:0] cfgOeDelay,
  input  logic [NBANK*WAIT_W-1:0] cfgWeDelay,
  input  logic [NBANK*WAIT_W-1:0] cfgPageWait,
  input  logic [NBANK*WAIT_W-1:0] cfgTurnWait,
  input  logic [BUS_W-1:0]        memDin,
  output logic                    isWrite,
  output logic                    lastSub,
  output logic [$clog2(NBANK)-1:0] bankSel,
  output logic [WAIT_W-1:0]       selRd,
  output logic [WAIT_W-1:0]       selWr,
  output logic [WAIT_W-1:0]       selOe,
  output logic [WAIT_W-1:0]       selWe,
  output logic [WAIT_W-1:0]       selPage,
  output logic [WAIT_W-1:0]       selTurn,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LANES-1:0]        memBlsN,
  output logic [BUS_W-1:0]        memDout,
  output logic [BUS_W-1:0]        rdata
);
  localparam int BANK_W = $clog2(NBANK);

  logic [1:0]        widArr  [NBANK];
  logic [WAIT_W-1:0] rdArr   [NBANK];
  logic [WAIT_W-1:0] wrArr   [NBANK];
  logic [WAIT_W-1:0] oeArr   [NBANK];
  logic [WAIT_W-1:0] weArr   [NBANK];
  logic [WAIT_W-1:0] pageArr [NBANK];
  logic [WAIT_W-1:0] turnArr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_unpack
    assign widArr[g]  = cfgWidth[2*g +: 2];
    assign rdArr[g]   = cfgRdWait[g*WAIT_W +: WAIT_W];
    assign wrArr[g]   = cfgWrWait[g*WAIT_W +: WAIT_W];
    assign oeArr[g]   = cfgOeDelay[g*WAIT_W +: WAIT_W];
    assign weArr[g]   = cfgWeDelay[g*WAIT_W +: WAIT_W];
    assign pageArr[g] = cfgPageWait[g*WAIT_W +: WAIT_W];
    assign turnArr[g] = cfgTurnWait[g*WAIT_W +: WAIT_W];
  end

  logic [BANK_W-1:0] bankR;
  logic              writeR;
  logic [1:0]        sizeR;
  logic [ADDR_W-1:0] addrR;
  logic [BUS_W-1:0]  wdataR;
  logic [1:0]        idx;
  logic [BUS_W-1:0]  assembleR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankR     <= '0;
      writeR    <= 1'b0;
      sizeR     <= 2'd0;
      addrR     <= '0;
      wdataR    <= '0;
      idx       <= 2'd0;
      assembleR <= '0;
    end else if (strobe.load) begin
      bankR     <= reqAddr[ADDR_W-1 -: BANK_W];
      writeR    <= reqWrite;
      sizeR     <= reqSize;
      addrR     <= reqAddr;
      wdataR    <= reqWdata;
      idx       <= 2'd0;
      assembleR <= '0;
    end else begin
      if (strobe.capture) assembleR <= rdata;
      if (strobe.step)    idx <= idx + 2'd1;
    end
  end

  assign isWrite = writeR;
  assign bankSel = bankR;
  assign selRd   = rdArr[bankR];
  assign selWr   = wrArr[bankR];
  assign selOe   = oeArr[bankR];
  assign selWe   = weArr[bankR];
  assign selPage = pageArr[bankR];
  assign selTurn = turnArr[bankR];

  // log2 byte counts: bank width, transfer size, per-access unit
  logic [1:0] wLog, sLog, uLog, subLog;
  logic [2:0] nSub;
  logic [1:0] pieceByte, laneMask, off;
  logic [3:0] byteEn;
  logic [6:0] laneShift;
  logic [BUS_W-1:0] dataMask, readPiece;
  logic [ADDR_W-1:0] subAddr;

  always_comb begin
    wLog      = (widArr[bankR] == 2'd0) ? 2'd0 : (widArr[bankR] == 2'd1) ? 2'd1 : 2'd2;
    sLog      = (sizeR == 2'd3) ? 2'd2 : sizeR;
    uLog      = (sLog < wLog) ? sLog : wLog;
    subLog    = sLog - uLog;
    nSub      = 3'd1 << subLog;
    lastSub   = ({1'b0, idx} == (nSub - 3'd1));
    pieceByte = idx << uLog;
    subAddr   = addrR + ADDR_W'(pieceByte);
    laneMask  = 2'((3'd1 << wLog) - 3'd1);
    off       = subAddr[1:0] & laneMask;
    byteEn    = 4'((5'd1 << (3'd1 << uLog)) - 5'd1);
    laneShift = {3'b000, byteEn} << off;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign dataMask[8*l +: 8] = {8{byteEn[l]}};
  end

  assign memAddr   = subAddr;
  assign memBlsN   = ~laneShift[LANES-1:0];
  assign memDout   = ((wdataR >> {pieceByte, 3'b000}) & dataMask) << {off, 3'b000};
  assign readPiece = (memDin >> {off, 3'b000}) & dataMask;
  assign rdata     = assembleR | (readPiece << {pieceByte, 3'b000});
endmodule

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              isWrite,
  input  logic              lastSub,
  input  logic [WAIT_W-1:0] selRd,
  input  logic [WAIT_W-1:0] selWr,
  input  logic [WAIT_W-1:0] selOe,
  input  logic [WAIT_W-1:0] selWe,
  input  logic [WAIT_W-1:0] selPage,
  input  logic [WAIT_W-1:0] selTurn,
  output dpStrobeT          strobe,
  output logic              csActive,
  output logic              oeActive,
  output logic              weActive,
  output logic              rdy
);
  seqStateT          state;
  logic [WAIT_W-1:0] tCnt, gapCnt;
  logic              inPage, resumeAcc;

  logic [WAIT_W-1:0] oeStart, weStart, gapLen;
  logic              phaseLast, endOfAcc;

  always_comb begin
    oeStart   = (selOe > selRd) ? selRd : selOe;
    weStart   = (selWe > selWr) ? selWr : selWe;
    gapLen    = (isWrite && selTurn == '0) ? WAIT_W'(1) : selTurn;
    phaseLast = inPage ? (tCnt == selPage) : isWrite ? (tCnt == selWr) : (tCnt == selRd);
    csActive  = (state == ST_ACC);
    endOfAcc  = csActive && phaseLast;
    oeActive  = csActive && !isWrite && (inPage || tCnt >= oeStart);
    weActive  = csActive && isWrite && (tCnt >= weStart);
    rdy       = endOfAcc && lastSub;
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.capture = endOfAcc && !isWrite;
    strobe.step    = endOfAcc && !lastSub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tCnt      <= '0;
      gapCnt    <= '0;
      inPage    <= 1'b0;
      resumeAcc <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_ACC;
            tCnt   <= '0;
            inPage <= 1'b0;
          end
        end
        ST_ACC: begin
          if (!phaseLast) begin
            tCnt <= tCnt + WAIT_W'(1);
          end else begin
            tCnt <= '0;
            if (!lastSub) begin
              if (isWrite) begin
                state     <= ST_TURN;
                gapCnt    <= gapLen;
                resumeAcc <= 1'b1;
              end else begin
                inPage <= 1'b1;
              end
            end else begin
              inPage    <= 1'b0;
              resumeAcc <= 1'b0;
              if (gapLen != '0) begin
                state  <= ST_TURN;
                gapCnt <= gapLen;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_TURN: begin
          if (gapCnt == WAIT_W'(1)) begin
            state <= resumeAcc ? ST_ACC : ST_IDLE;
            tCnt  <= '0;
          end else begin
            gapCnt <= gapCnt - WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smemSeq.sv
module smemSeq
  import smemPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NBANK  = 4,
  parameter int WAIT_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [31:0]             reqWdata,
  output logic                    rdy,
  output logic [31:0]             rdata,
  input  logic [2*NBANK-1:0]      cfgWidth,
  input  logic [NBANK*WAIT_W-1:0] cfgRdWait,
  input  logic [NBANK*WAIT_W-1:0] cfgWrWait,
  input  logic [NBANK*WAIT_W-1:0] cfgOeDelay,
  input  logic [NBANK*WAIT_W-1:0] cfgWeDelay,
  input  logic [NBANK*WAIT_W-1:0] cfgPageWait,
  input  logic [NBANK*WAIT_W-1:0] cfgTurnWait,
  output logic [NBANK-1:0]        memCsN,
  output logic                    memOeN,
  output logic                    memWeN,
  output logic [3:0]              memBlsN,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [31:0]             memDout,
  input  logic [31:0]             memDin
);
  localparam int BANK_W = $clog2(NBANK);

  dpStrobeT          strobe;
  logic              isWrite, lastSub, csActive, oeActive, weActive;
  logic [BANK_W-1:0] bankSel;
  logic [WAIT_W-1:0] selRd, selWr, selOe, selWe, selPage, selTurn;

  smemDatapath #(.ADDR_W(ADDR_W), .NBANK(NBANK), .WAIT_W(WAIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWidth(cfgWidth), .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait),
    .cfgOeDelay(cfgOeDelay), .cfgWeDelay(cfgWeDelay),
    .cfgPageWait(cfgPageWait), .cfgTurnWait(cfgTurnWait),
    .memDin(memDin), .isWrite(isWrite), .lastSub(lastSub), .bankSel(bankSel),
    .selRd(selRd), .selWr(selWr), .selOe(selOe), .selWe(selWe),
    .selPage(selPage), .selTurn(selTurn),
    .memAddr(memAddr), .memBlsN(memBlsN), .memDout(memDout), .rdata(rdata)
  );

  smemCtrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .isWrite(isWrite), .lastSub(lastSub),
    .selRd(selRd), .selWr(selWr), .selOe(selOe), .selWe(selWe),
    .selPage(selPage), .selTurn(selTurn),
    .strobe(strobe), .csActive(csActive), .oeActive(oeActive),
    .weActive(weActive), .rdy(rdy)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign memCsN[g] = !(csActive && bankSel == BANK_W'(g));
  end

  assign memOeN = !oeActive;
  assign memWeN = !weActive;
endmodule

// File: rtl/smemSeqChk.sv
module smemSeqChk #(
  parameter int ADDR_W = 12,
  parameter int NBANK  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdy,
  input logic [NBANK-1:0]  memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int BANK_W = $clog2(NBANK);

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  assert_cs_bank_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memCsN != {NBANK{1'b1}}) |-> !memCsN[memAddr[ADDR_W-1 -: BANK_W]]);

  assert_oe_we_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> (memCsN != {NBANK{1'b1}}));

  assert_we_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !rdy) |=> (!memWeN || memCsN == {NBANK{1'b1}}));

  assert_rdy_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdy |=> !rdy);

  assert_rdy_in_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> (memCsN != {NBANK{1'b1}}));
endmodule

bind smemSeq smemSeqChk #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_chk (
  .clk(clk), .rstN(rstN), .rdy(rdy), .memCsN(memCsN),
  .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr)
);

// File: tb/smemSeq_tb.sv
`timescale 1ns/100ps
module smemSeq_tb;
  localparam int ADDR_W = 12;
  localparam int NBANK  = 4;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rdy;
  logic [31:0] rdata;
  logic [2*NBANK-1:0] cfgWidth;
  logic [NBANK*WAIT_W-1:0] cfgRdWait, cfgWrWait, cfgOeDelay, cfgWeDelay, cfgPageWait, cfgTurnWait;
  logic [NBANK-1:0] memCsN;
  logic memOeN, memWeN;
  logic [3:0] memBlsN;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memDout;
  logic [31:0] memDin;

  // per-bank configuration of the bench
  int cW[4]  = '{0, 1, 2, 0};
  int cRd[4] = '{2, 1, 0, 3};
  int cWr[4] = '{1, 2, 0, 2};
  int cOe[4] = '{1, 0, 0, 5};
  int cWe[4] = '{0, 1, 0, 4};
  int cPg[4] = '{0, 1, 0, 2};
  int cTn[4] = '{2, 0, 0, 1};

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      cfgWidth[2*b +: 2]         = 2'(cW[b]);
      cfgRdWait[4*b +: 4]        = 4'(cRd[b]);
      cfgWrWait[4*b +: 4]        = 4'(cWr[b]);
      cfgOeDelay[4*b +: 4]       = 4'(cOe[b]);
      cfgWeDelay[4*b +: 4]       = 4'(cWe[b]);
      cfgPageWait[4*b +: 4]      = 4'(cPg[b]);
      cfgTurnWait[4*b +: 4]      = 4'(cTn[b]);
    end
  end

  smemSeq #(.ADDR_W(ADDR_W), .NBANK(NBANK), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdy(rdy), .rdata(rdata), .cfgWidth(cfgWidth),
    .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait), .cfgOeDelay(cfgOeDelay),
    .cfgWeDelay(cfgWeDelay), .cfgPageWait(cfgPageWait), .cfgTurnWait(cfgTurnWait),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memBlsN(memBlsN),
    .memAddr(memAddr), .memDout(memDout), .memDin(memDin)
  );

  // byte-addressed external memory model, one array per bank
  logic [7:0] mem [4][256];

  always_comb begin
    int bk, wb, base;
    memDin = '0;
    bk = int'(memAddr[11:10]);
    wb = 1 << cW[bk];
    base = int'(memAddr[7:0]) & ~(wb - 1);
    if (memCsN != 4'hF && !memOeN)
      for (int l = 0; l < 4; l++)
        if (l < wb) memDin[8*l +: 8] = mem[bk][8'(base + l)];
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 256; a++)
          mem[b][a] <= 8'(a * 13 + b * 61 + 5);
    end else if (memCsN != 4'hF && !memWeN) begin
      int bk, wb, base;
      bk = int'(memAddr[11:10]);
      wb = 1 << cW[bk];
      base = int'(memAddr[7:0]) & ~(wb - 1);
      for (int l = 0; l < 4; l++)
        if (l < wb && !memBlsN[l]) mem[bk][8'(base + l)] <= memDout[8*l +: 8];
    end
  end

  int total = 0, bad = 0;
  int prevGap = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int b, input int sz, input int a, input bit wr, input logic [31:0] wd);
    int sb, wb, n, pre, cyc, weL, oeL, csBad, guard;
    int expCyc, expWe, expOe, oeS, weS, gapW;
    logic [31:0] expRd, got;
    logic [7:0] below, above;
    sb = 1 << sz;
    wb = 1 << cW[b];
    n = (sb > wb) ? sb / wb : 1;
    expRd = '0;
    for (int k = 0; k < sb; k++) expRd[8*k +: 8] = mem[b][8'(a + k)];
    below = mem[b][8'(a - 1)];
    above = mem[b][8'(a + sb)];
    reqValid = 1'b1; reqWrite = wr; reqSize = 2'(sz);
    reqAddr = {2'(b), 2'b00, 8'(a)}; reqWdata = wd;
    pre = 0; cyc = 0; weL = 0; oeL = 0; csBad = 0; guard = 0; got = '0;
    while (guard < 500) begin
      guard++;
      @(negedge clk);
      if (memCsN == 4'hF) begin
        if (cyc == 0) pre++; else cyc++;
      end else begin
        cyc++;
        if (memCsN != ~(4'b0001 << b)) csBad++;
        if (!memWeN) weL++;
        if (!memOeN) oeL++;
        if (rdy) begin got = rdata; break; end
      end
    end
    reqValid = 1'b0;
    @(posedge clk); #1;
    chk(guard < 500, "R8 completion seen", 32'(guard), 32'd0);
    chk(rdy == 1'b0, "R8 rdy single pulse", 32'(rdy), 32'd0);
    chk(csBad == 0, "R1 only selected bank cs", 32'(csBad), 32'd0);
    chk(pre == prevGap + 1, "R7 idle cycles before access", 32'(pre), 32'(prevGap + 1));
    if (wr) begin
      gapW = (cTn[b] == 0) ? 1 : cTn[b];
      weS = (cWe[b] > cWr[b]) ? cWr[b] : cWe[b];
      expCyc = n * (cWr[b] + 1) + (n - 1) * gapW;
      expWe = n * (cWr[b] + 1 - weS);
      chk(cyc == expCyc, "R2/R6/R7 write cycle count", 32'(cyc), 32'(expCyc));
      chk(weL == expWe, "R6 write enable low cycles", 32'(weL), 32'(expWe));
      chk(oeL == 0, "R6 no output enable on write", 32'(oeL), 32'd0);
      for (int k = 0; k < sb; k++)
        chk(mem[b][8'(a + k)] == wd[8*k +: 8], "R3 written byte order",
            32'(mem[b][8'(a + k)]), 32'(wd[8*k +: 8]));
      chk(mem[b][8'(a - 1)] == below && mem[b][8'(a + sb)] == above, "R3 neighbour bytes kept",
          {mem[b][8'(a - 1)], mem[b][8'(a + sb)]}, {below, above});
      prevGap = gapW;
    end else begin
      oeS = (cOe[b] > cRd[b]) ? cRd[b] : cOe[b];
      expCyc = (cRd[b] + 1) + (n - 1) * (cPg[b] + 1);
      expOe = (cRd[b] + 1 - oeS) + (n - 1) * (cPg[b] + 1);
      chk(cyc == expCyc, "R2/R4/R5 read cycle count", 32'(cyc), 32'(expCyc));
      chk(oeL == expOe, "R4/R5 output enable low cycles", 32'(oeL), 32'(expOe));
      chk(weL == 0, "R6 no write enable on read", 32'(weL), 32'd0);
      chk(got == expRd, "R3/R8 read data assembly", got, expRd);
      prevGap = cTn[b];
    end
  endtask

  initial begin
    #(100000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(memCsN == 4'hF && memOeN && memWeN && !rdy, "R9 strobes idle in reset",
        {memCsN, memOeN, memWeN, rdy}, {4'hF, 1'b1, 1'b1, 1'b0});
    rstN = 1'b1;
    @(negedge clk);
    chk(memCsN == 4'hF && memOeN && memWeN && !rdy, "R9 idle after reset",
        {memCsN, memOeN, memWeN, rdy}, {4'hF, 1'b1, 1'b1, 1'b0});
    @(posedge clk); #1;
    for (int b = 0; b < 4; b++)
      for (int sz = 0; sz < 3; sz++)
        for (int j = 0; j < 4; j++) begin
          int a;
          logic [31:0] wd;
          a = 16 * j + 40 + ((sz == 0) ? j : (sz == 1) ? 2 * (j % 2) : 0);
          wd = 32'hA5C3_0000 ^ 32'(b << 20) ^ 32'(sz << 12) ^ 32'(j * 32'h1111_0111);
          xfer(b, sz, a, 1'b1, wd);
          xfer(b, sz, a, 1'b0, 32'd0);
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule